// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block chooses where each of the two ALU operands of a five-stage pipeline comes from. It looks at the two source register numbers of the instruction now in the execute stage. It compares them with the destination register numbers of the two older instructions, which sit in the memory stage and the write-back stage. When an older instruction is about to write a register that the execute stage reads, the result is bypassed to the ALU instead of the stale register-file value.

Each comparison counts only when the older stage really writes a register: its write enable must be set, and its destination must not be register zero, which always reads as zero. When both older stages target the same register, the memory-stage result wins because it is the newer one. A result three instructions back needs no bypass: the register file writes in the first half of the cycle and reads in the second half.

The block is purely combinational. Besides the two 2-bit selects, it holds the two operand multiplexers, so the selection can be checked on real data values. Stall detection and the register file itself sit outside this block.

Top module: `fwd_operand_path`

## Requirements
- R1: With no qualifying match, both selects are 00 (register file), `alu_a` equals `rf_a` and `alu_b` equals `rf_b`.
- R2: When `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_rs`, `fwd_a_sel` is 10 and `alu_a` equals `mem_result`.
- R3: When `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_rt`, `fwd_b_sel` is 10 and `alu_b` equals `mem_result`.
- R4: When only the write-back stage qualifies (`wb_wen` is 1, `wb_dst` is nonzero and equal to `ex_rs`), `fwd_a_sel` is 01 and `alu_a` equals `wb_value`.
- R5: When only the write-back stage qualifies for `ex_rt`, `fwd_b_sel` is 01 and `alu_b` equals `wb_value`.
- R6: When both stages qualify for the same source, the select is 10 and the memory-stage result is used.
- R7: A stage whose write enable is 0 never causes a bypass, even when its destination matches.
- R8: A destination of register 0 never causes a bypass, even with its write enable at 1.
- R9: When `ex_rs` equals `ex_rt`, both selects are equal and both operands receive the same bypassed value.
- R10: Operand A and operand B select independently: a match on one source leaves the other at its own selection. The select value 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_AW | First source register number of the execute-stage instruction |
| ex_rt | input | REG_AW | Second source register number of the execute-stage instruction |
| mem_dst | input | REG_AW | Destination register number held in the memory stage |
| mem_wen | input | 1 | Register-write enable of the memory-stage instruction |
| wb_dst | input | REG_AW | Destination register number held in the write-back stage |
| wb_wen | input | 1 | Register-write enable of the write-back-stage instruction |
| rf_a | input | DATA_W | Register-file value read for the first source |
| rf_b | input | DATA_W | Register-file value read for the second source |
| mem_result | input | DATA_W | ALU result carried by the memory stage |
| wb_value | input | DATA_W | Value being written back by the write-back stage |
| fwd_a_sel | output | 2 | Operand A select: 00 register file, 10 memory stage, 01 write-back |
| fwd_b_sel | output | 2 | Operand B select, same encoding |
| alu_a | output | DATA_W | Selected first ALU operand |
| alu_b | output | DATA_W | Selected second ALU operand |

## Verification
The block holds no state. Any wrong comparison or priority shows at the select ports and on the operand data in the same evaluation as the stimulus that caused it. Each scenario uses distinct data values for the register file, the memory stage and the write-back stage. A wrong select therefore always shows up as a different operand value. A swapped priority only shows when both stages match, and a missing enable or zero qualifier only shows when a matching destination has that qualifier cleared. The directed cases set up exactly those situations.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic              wen,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // A stage qualifies only if it writes and its target is not the hardwired zero register.
    always_comb begin
        hit = wen && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import fwd_pkg::*;
(
    input  logic     hit_newer,
    input  logic     hit_older,
    output fwd_sel_e sel
);
    // The memory stage holds the younger result, so it is checked first.
    always_comb begin
        if (hit_newer)      sel = FWD_MEM;
        else if (hit_older) sel = FWD_WB;
        else                sel = FWD_RF;
    end
endmodule

// File: rtl/operand_mux.sv
module operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] op_out
);
    always_comb begin
        case (sel)
            FWD_MEM: op_out = mem_val;
            FWD_WB:  op_out = wb_val;
            default: op_out = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_operand_path.sv
module fwd_operand_path
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_rs,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wen,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] mem_result,
    input  logic [DATA_W-1:0] wb_value,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b
);
    localparam int NUM_OPS = 2;
    localparam int OP_A    = 0;
    localparam int OP_B    = 1;

    logic [REG_AW-1:0] src_v   [NUM_OPS];
    logic [DATA_W-1:0] rf_v    [NUM_OPS];
    logic [DATA_W-1:0] out_v   [NUM_OPS];
    logic              hit_mem [NUM_OPS];
    logic              hit_wb  [NUM_OPS];
    fwd_sel_e          sel_v   [NUM_OPS];

    always_comb begin
        src_v[OP_A] = ex_rs;
        src_v[OP_B] = ex_rt;
        rf_v[OP_A]  = rf_a;
        rf_v[OP_B]  = rf_b;
    end

    // One identical comparison, priority and mux slice per ALU operand.
    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        fwd_hit #(.REG_AW(REG_AW)) u_hit_mem (
            .src (src_v[op]),
            .dst (mem_dst),
            .wen (mem_wen),
            .hit (hit_mem[op])
        );

        fwd_hit #(.REG_AW(REG_AW)) u_hit_wb (
            .src (src_v[op]),
            .dst (wb_dst),
            .wen (wb_wen),
            .hit (hit_wb[op])
        );

        fwd_prio u_prio (
            .hit_newer (hit_mem[op]),
            .hit_older (hit_wb[op]),
            .sel       (sel_v[op])
        );

        operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_v[op]),
            .rf_val  (rf_v[op]),
            .mem_val (mem_result),
            .wb_val  (wb_value),
            .op_out  (out_v[op])
        );
    end

    always_comb begin
        fwd_a_sel = sel_v[OP_A];
        fwd_b_sel = sel_v[OP_B];
        alu_a     = out_v[OP_A];
        alu_b     = out_v[OP_B];
    end

    // Port-level consistency checks between the select logic and the data muxes.
    always_comb begin
        assert_sel_legal_R10: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
            else $error("illegal select value");
        assert_mem_data_R2: assert (fwd_a_sel != 2'b10 || alu_a == mem_result)
            else $error("operand A not memory result");
        assert_wb_data_R5: assert (fwd_b_sel != 2'b01 || alu_b == wb_value)
            else $error("operand B not write-back value");
        assert_idle_R1: assert (fwd_a_sel != 2'b00 || alu_a == rf_a)
            else $error("operand A not register file");
        assert_no_wen_R7: assert (mem_wen || wb_wen || (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00))
            else $error("bypass without any write enable");
        assert_zero_dst_R8: assert (mem_dst != '0 || wb_dst != '0
                                    || (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00))
            else $error("bypass from register zero");
        assert_same_src_R9: assert (ex_rs != ex_rt || fwd_a_sel == fwd_b_sel)
            else $error("equal sources selected differently");
        assert_wb_never_shadows_R6: assert (fwd_a_sel != 2'b01 || !(mem_wen && mem_dst == ex_rs && mem_dst != '0))
            else $error("older result chosen over newer");
    end
endmodule

// File: tb/fwd_operand_path_bench.sv
module fwd_operand_path_bench;
    localparam int DATA_W = 32;
    localparam int REG_AW = 5;
    localparam logic [DATA_W-1:0] V_RFA = 32'h1111_0001;
    localparam logic [DATA_W-1:0] V_RFB = 32'h2222_0002;
    localparam logic [DATA_W-1:0] V_MEM = 32'h3333_0003;
    localparam logic [DATA_W-1:0] V_WB  = 32'h4444_0004;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [REG_AW-1:0] ex_rs = '0, ex_rt = '0, mem_dst = '0, wb_dst = '0;
    logic              mem_wen = 1'b0, wb_wen = 1'b0;
    logic [DATA_W-1:0] rf_a = '0, rf_b = '0, mem_result = '0, wb_value = '0;
    logic [1:0]        fwd_a_sel, fwd_b_sel;
    logic [DATA_W-1:0] alu_a, alu_b;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    fwd_operand_path #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_fwd_operand_path (
        .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .rf_a(rf_a), .rf_b(rf_b),
        .mem_result(mem_result), .wb_value(wb_value),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .alu_a(alu_a), .alu_b(alu_b)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [REG_AW-1:0] rs, input logic [REG_AW-1:0] rt,
                         input logic [REG_AW-1:0] md, input logic mw,
                         input logic [REG_AW-1:0] wd, input logic ww);
        @(posedge clk);
        ex_rs = rs; ex_rt = rt; mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
        rf_a = V_RFA; rf_b = V_RFB; mem_result = V_MEM; wb_value = V_WB;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [1:0] sa, input logic [1:0] sb,
                              input logic [DATA_W-1:0] va, input logic [DATA_W-1:0] vb);
        chk({req, " sel_a"}, {30'd0, fwd_a_sel}, {30'd0, sa});
        chk({req, " sel_b"}, {30'd0, fwd_b_sel}, {30'd0, sb});
        chk({req, " alu_a"}, alu_a, va);
        chk({req, " alu_b"}, alu_b, vb);
    endtask

    task automatic t_reset_idle();
        @(negedge clk);
        // R1: all-zero inputs give register-file selection
        chk("R1 reset sel_a", {30'd0, fwd_a_sel}, 32'd0);
        chk("R1 reset sel_b", {30'd0, fwd_b_sel}, 32'd0);
    endtask

    task automatic t_no_match();
        apply(5'd3, 5'd4, 5'd5, 1'b1, 5'd6, 1'b1);
        expect_out("R1 no match", 2'b00, 2'b00, V_RFA, V_RFB);
    endtask

    task automatic t_case_1a();
        apply(5'd2, 5'd4, 5'd2, 1'b1, 5'd9, 1'b1);
        expect_out("R2 R10 mem to A", 2'b10, 2'b00, V_MEM, V_RFB);
    endtask

    task automatic t_case_1b();
        apply(5'd1, 5'd2, 5'd2, 1'b1, 5'd9, 1'b1);
        expect_out("R3 R10 mem to B", 2'b00, 2'b10, V_RFA, V_MEM);
    endtask

    task automatic t_case_2a();
        apply(5'd2, 5'd5, 5'd12, 1'b1, 5'd2, 1'b1);
        expect_out("R4 wb to A", 2'b01, 2'b00, V_WB, V_RFB);
    endtask

    task automatic t_case_2b();
        apply(5'd6, 5'd2, 5'd13, 1'b1, 5'd2, 1'b1);
        expect_out("R5 wb to B", 2'b00, 2'b01, V_RFA, V_WB);
    endtask

    task automatic t_mixed();
        apply(5'd7, 5'd8, 5'd7, 1'b1, 5'd8, 1'b1);
        expect_out("R10 A from mem B from wb", 2'b10, 2'b01, V_MEM, V_WB);
    endtask

    task automatic t_both_stages();
        apply(5'd7, 5'd7, 5'd7, 1'b1, 5'd7, 1'b1);
        expect_out("R6 newer wins", 2'b10, 2'b10, V_MEM, V_MEM);
        apply(5'd11, 5'd3, 5'd11, 1'b1, 5'd11, 1'b1);
        expect_out("R6 newer wins A only", 2'b10, 2'b00, V_MEM, V_RFB);
    endtask

    task automatic t_wen_low();
        apply(5'd4, 5'd1, 5'd4, 1'b0, 5'd4, 1'b1);
        expect_out("R7 mem disabled falls to wb", 2'b01, 2'b00, V_WB, V_RFB);
        apply(5'd4, 5'd4, 5'd4, 1'b0, 5'd4, 1'b0);
        expect_out("R7 both disabled", 2'b00, 2'b00, V_RFA, V_RFB);
    endtask

    task automatic t_zero_dst();
        apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        expect_out("R8 zero register", 2'b00, 2'b00, V_RFA, V_RFB);
        apply(5'd0, 5'd3, 5'd0, 1'b1, 5'd3, 1'b1);
        expect_out("R8 zero mem dst, wb still works", 2'b00, 2'b01, V_RFA, V_WB);
    endtask

    task automatic t_same_reg();
        apply(5'd9, 5'd9, 5'd9, 1'b1, 5'd1, 1'b1);
        expect_out("R9 both from mem", 2'b10, 2'b10, V_MEM, V_MEM);
        apply(5'd31, 5'd31, 5'd2, 1'b1, 5'd31, 1'b1);
        expect_out("R9 both from wb", 2'b01, 2'b01, V_WB, V_WB);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_no_match();
        t_case_1a();
        t_case_1b();
        t_case_2a();
        t_case_2b();
        t_mixed();
        t_both_stages();
        t_wen_low();
        t_zero_dst();
        t_same_reg();
        finished = 1'b1;
        finish_run();
    end
endmodule